// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page translations. A request carries a virtual address. Its page number is compared against every stored entry in the same cycle. On a hit, the response gives the stored frame number joined with the untouched page offset. On a miss, the response flags the miss. The external table walker then resolves the page and writes the page/frame pair back through the refill port. The next access to that page then hits.

Eight entries are kept in true least-recently-used order. Empty slots are used before any live translation is evicted. After that, a refill replaces whichever entry was used least recently. A flush input wipes all translations in one cycle when the address space changes. Two free-running counters count requests and hits, so the hit ratio can be computed outside the block.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no entry is valid, `rsp_valid`, `rsp_hit` and `rsp_miss` are low, and both counters read zero.
- R2: A request with `req_valid` high gets its answer on the next cycle: `rsp_valid` goes high. If the page number `req_vaddr[31:12]` matches a valid entry, `rsp_hit` is high and `rsp_paddr` equals `{frame, req_vaddr[11:0]}`.
- R3: A request whose page number matches no valid entry answers with `rsp_miss` high, `rsp_hit` low and `rsp_paddr` zero. `rsp_hit` and `rsp_miss` are never high together.
- R4: A refill (`fill_valid` with `fill_vpn`, `fill_pfn`) stores the pair, so a later request for that page hits with that frame.
- R5: While empty slots remain, a refill takes an empty slot, so eight distinct refills after reset or flush all stay resident.
- R6: When all slots are valid, a refill evicts the least recently used entry. Both a hit and a refill make the touched entry the most recently used.
- R7: A refill for a page already present overwrites that entry's frame and does not create a second copy.
- R8: A flush invalidates every entry in one cycle. A request in the flush cycle answers as a miss, and a refill in the flush cycle is discarded.
- R9: A request in the same cycle as a refill is answered from the contents before that refill.
- R10: `access_count` increases by one for each request, and `hit_count` increases by one for each request answered as a hit.
- R11: At most one valid entry ever matches a given page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | 20 | Page number being refilled |
| fill_pfn | input | 20 | Frame number for that page |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_hit | output | 1 | Response was a hit |
| rsp_miss | output | 1 | Response was a miss |
| rsp_paddr | output | 32 | Translated physical address (zero on miss) |
| access_count | output | 32 | Number of requests seen |
| hit_count | output | 32 | Number of hits |

## Verification
The bench fills all eight slots and then touches the oldest page before one more refill. A design with FIFO replacement, or one that forgets to refresh on a hit, would evict the page just used rather than the second-oldest. It refills a resident page with a new frame whose bits differ from the old one. A design that allocates a second copy would OR two frames together on the next hit. It also drives a flush together with a request and a refill, and a refill together with a lookup of the same page. A design with the wrong priority in these cycles would report a hit from a flushed or not-yet-written entry, or keep a refill that should have been dropped.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int DEF_ENTRIES = 8;
  localparam int DEF_VA_W    = 32;
  localparam int DEF_OFF_W   = 12;
  localparam int DEF_PFN_W   = 20;
  localparam int DEF_CNT_W   = 32;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20
) (
  input  logic [TAG_W-1:0]   tags [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  logic [TAG_W-1:0]   key,
  output logic [ENTRIES-1:0] match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  // Age 0 is most recent, ENTRIES-1 is least recent; ages form a permutation.
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  always_comb begin
    touched_age = age_q[touch_idx];
    oldest_idx  = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)       age_q[i] <= '0;
        else if (age_q[i] < touched_age)  age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = xlat_pkg::DEF_ENTRIES,
  parameter int VA_W    = xlat_pkg::DEF_VA_W,
  parameter int OFF_W   = xlat_pkg::DEF_OFF_W,
  parameter int PFN_W   = xlat_pkg::DEF_PFN_W,
  parameter int CNT_W   = xlat_pkg::DEF_CNT_W,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [CNT_W-1:0] access_count,
  output logic [CNT_W-1:0] hit_count
);
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  logic [VPN_W-1:0]   req_vpn;
  logic [ENTRIES-1:0] look_match, fill_match;
  logic [IDX_W-1:0]   look_idx, fmatch_idx, free_idx, oldest_idx, fill_idx, touch_idx;
  logic               free_any, look_hit, fill_go, touch_en;
  logic [PFN_W-1:0]   look_pfn;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];

  xlat_cam #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_look_cam (
    .tags(tag_q), .valid(valid_q), .key(req_vpn), .match(look_match)
  );

  xlat_cam #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_fill_cam (
    .tags(tag_q), .valid(valid_q), .key(fill_vpn), .match(fill_match)
  );

  xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en),
    .touch_idx(touch_idx), .oldest_idx(oldest_idx)
  );

  // Index encoding, lowest free slot and one-hot frame select.
  always_comb begin
    look_idx   = '0;
    fmatch_idx = '0;
    free_idx   = '0;
    free_any   = 1'b0;
    look_pfn   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (look_match[i]) look_idx   = IDX_W'(i);
      if (fill_match[i]) fmatch_idx = IDX_W'(i);
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++)
      look_pfn = look_pfn | (pfn_q[i] & {PFN_W{look_match[i]}});
  end

  assign look_hit  = req_valid && (|look_match) && !flush;
  assign fill_go   = fill_valid && !flush;
  assign fill_idx  = (|fill_match) ? fmatch_idx : (free_any ? free_idx : oldest_idx);
  assign touch_en  = fill_go || (look_hit && !fill_valid);
  assign touch_idx = fill_go ? fill_idx : look_idx;

  // Entry storage: plain write port, no reset on the data arrays.
  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[fill_idx] <= fill_vpn;
      pfn_q[fill_idx] <= fill_pfn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)  valid_q <= '0;
    else if (fill_go)  valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_paddr    <= '0;
      access_count <= '0;
      hit_count    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= look_hit;
      rsp_miss  <= req_valid && !look_hit;
      rsp_paddr <= look_hit ? {look_pfn, req_vaddr[OFF_W-1:0]} : '0;
      if (req_valid) access_count <= access_count + 1'b1;
      if (look_hit)  hit_count    <= hit_count + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               req_valid,
  input logic [OFF_W-1:0]   req_off,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [CNT_W-1:0]   access_count,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] look_match
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss);
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !rsp_hit || (rsp_paddr[OFF_W-1:0] == $past(req_off)));
  a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss));
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));
  a_r8_flush_req_misses: assert property (@(posedge clk) disable iff (rst)
    (flush && req_valid) |=> rsp_miss);
  a_r10_access_count: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> access_count == $past(access_count) + 1'b1);
  a_r11_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_match));
endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .OFF_W(OFF_W), .PA_W(PA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
  .req_off(req_vaddr[OFF_W-1:0]), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr), .access_count(access_count),
  .valid_q(valid_q), .look_match(look_match)
);

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
  logic        clk = 1'b0;
  logic        rst, flush, req_valid, fill_valid;
  logic [31:0] req_vaddr;
  logic [19:0] fill_vpn, fill_pfn;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_paddr, access_count, hit_count;

  int total = 0, bad = 0;
  int exp_acc = 0, exp_hits = 0;

  always #2 clk = ~clk;

  xlat_cache dut (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .access_count(access_count), .hit_count(hit_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One lookup; response checked one cycle later (R2/R3).
  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                        input bit exp_hit, input logic [19:0] exp_pfn,
                        input string req);
    logic [31:0] exp_pa;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    @(negedge clk);
    req_valid = 1'b0;
    exp_acc++;
    if (exp_hit) exp_hits++;
    exp_pa = exp_hit ? {exp_pfn, off} : 32'h0;
    chk(rsp_valid && rsp_hit == exp_hit && rsp_miss == !exp_hit, req,
        "hit flag", {rsp_valid, rsp_hit, rsp_miss}, {1'b1, exp_hit, !exp_hit});
    chk(rsp_paddr == exp_pa, req, "paddr", rsp_paddr, exp_pa);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpn   = vpn;
    fill_pfn   = pfn;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; flush = 1'b0; req_valid = 1'b0; fill_valid = 1'b0;
    req_vaddr = '0; fill_vpn = '0; fill_pfn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!rsp_valid && !rsp_hit && !rsp_miss, "R1", "rsp idle",
        {rsp_valid, rsp_hit, rsp_miss}, 0);
    chk(access_count == 0 && hit_count == 0, "R1", "counters",
        {access_count, hit_count}, 0);
    lookup(20'h00000, 12'h000, 1'b0, '0, "R1");
  endtask

  task automatic t_basic();
    lookup(20'h12345, 12'h678, 1'b0, '0, "R3");
    fill(20'h12345, 20'hABCDE);
    lookup(20'h12345, 12'h678, 1'b1, 20'hABCDE, "R4");
    lookup(20'h12345, 12'hFFF, 1'b1, 20'hABCDE, "R2");
    lookup(20'h12346, 12'h001, 1'b0, '0, "R3");
  endtask

  task automatic t_fill_all_and_lru();
    do_flush();
    for (int i = 0; i < 8; i++) fill(20'h100 + 20'(i), 20'h5000 + 20'(i));
    for (int i = 0; i < 8; i++)
      lookup(20'h100 + 20'(i), 12'(i * 3), 1'b1, 20'h5000 + 20'(i), "R5");
    // Order now oldest-first: 100..107. Touch 100, 101 becomes oldest.
    lookup(20'h100, 12'h010, 1'b1, 20'h5000, "R6");
    fill(20'h1F0, 20'h6000);
    lookup(20'h101, 12'h020, 1'b0, '0, "R6");
    lookup(20'h100, 12'h030, 1'b1, 20'h5000, "R6");
    lookup(20'h1F0, 12'h040, 1'b1, 20'h6000, "R6");
    // Next oldest is 102.
    fill(20'h1F1, 20'h6001);
    lookup(20'h102, 12'h050, 1'b0, '0, "R6");
    lookup(20'h103, 12'h060, 1'b1, 20'h5003, "R6");
  endtask

  task automatic t_refill_dup();
    do_flush();
    fill(20'h2222, 20'h0F0F0);
    fill(20'h2222, 20'hF0F00);
    lookup(20'h2222, 12'h123, 1'b1, 20'hF0F00, "R7");
  endtask

  task automatic t_flush();
    fill(20'h3333, 20'h44444);
    lookup(20'h3333, 12'h000, 1'b1, 20'h44444, "R8");
    // Request in the flush cycle must miss; refill in flush cycle dropped.
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_vaddr = {20'h3333, 12'h00C};
    fill_valid = 1'b1; fill_vpn = 20'h7777; fill_pfn = 20'h88888;
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0; fill_valid = 1'b0;
    exp_acc++;
    chk(rsp_miss && !rsp_hit, "R8", "req during flush", {rsp_hit, rsp_miss}, 2'b01);
    lookup(20'h3333, 12'h000, 1'b0, '0, "R8");
    lookup(20'h7777, 12'h000, 1'b0, '0, "R8");
    lookup(20'h2222, 12'h000, 1'b0, '0, "R8");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h9999; fill_pfn = 20'h11111;
    req_valid = 1'b1; req_vaddr = {20'h9999, 12'h0AA};
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b0;
    exp_acc++;
    chk(rsp_miss && !rsp_hit, "R9", "lookup with refill", {rsp_hit, rsp_miss}, 2'b01);
    lookup(20'h9999, 12'h0AA, 1'b1, 20'h11111, "R9");
  endtask

  task automatic t_counters();
    chk(access_count == 32'(exp_acc), "R10", "access_count", access_count, exp_acc);
    chk(hit_count == 32'(exp_hits), "R10", "hit_count", hit_count, exp_hits);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_fill_all_and_lru();
    t_refill_dup();
    t_flush();
    t_same_cycle();
    t_counters();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule